// File: doc/BRIEF.md
# Online register file tester

This block holds a 32-word register file with one pipeline read port and one pipeline write port. It checks that file for defects in the background. It borrows a port only in a cycle where the pipeline leaves that port unused, so normal execution is never stalled or disturbed.

Registers are tested one at a time, in ascending order, and the test steps through four phases:

1. **Copy.** The register's value is copied into a spare register, and accesses to that index are redirected to the spare.
2. **Write.** A pseudo-random word is written into the register.
3. **Check.** The word is read back and compared with what was written.
4. **Restore.** The saved value is written back and the redirect ends.

Read-back goes through the read-address decoder and the writes go through the separate write-address decoder, so both decoders are exercised by the test. Every compare produces a one-cycle result with its index. Any mismatch also sets a sticky error flag and captures the failing index.

For verification, a stuck-at-one hook can corrupt one bit of one register on every write into it.

Top module: `rf_online_tester`

## Requirements
- R1: A value written through the pipeline write port is returned by every later pipeline read of that index, whatever test activity takes place in between, unless the index has since been written again.
- R2: The test word is produced by a 32-bit Fibonacci LFSR. It shifts left, and its new bit 0 is the XOR of state bits 31, 21, 1 and 0 (polynomial x^32+x^22+x^2+x+1). The seed is 32'h1D87_2B41, and the LFSR steps once per register tested. The n-th register tested after reset (n from 0) is written and compared with the seed stepped n times.
- R3: The phases run strictly in the order copy, write, check, restore. Copy and check advance only in a cycle with `rd_en` low. Write and restore advance only in a cycle with `wr_en` low. Otherwise the test holds in its phase, with `test_idx` and `redir_on` unchanged.
- R4: With both ports idle, one compare result is produced every 4 cycles, so all 32 registers are covered in 128 cycles. Each result is a one-cycle `chk_valid` pulse, with the index on `chk_idx`.
- R5: Registers are tested in the order 0, 1, ..., 31, then testing wraps back to 0 and continues without end.
- R6: A mismatch raises `chk_fail` together with `chk_valid` and sets `err_flag`.
  - `err_idx` captures the failing index when the flag was clear, or when `err_clr` is high in the same cycle.
  - `err_flag` stays set until `err_clr` is high in a cycle with no new failure; a failure in the same cycle keeps it set.
- R7: While `redir_on` is high, a pipeline read of index `test_idx` returns the spare copy. A pipeline write to that index updates the spare, and the spare's value is what the restore phase writes back.
- R8: A pipeline write to the index under test in the same cycle as its copy phase is captured into the spare, and so it survives the test.
- R9: A synchronous active-low reset clears every register to 0 and sets `test_idx` to 0. It also clears `redir_on`, `chk_valid`, `chk_fail`, `chk_idx`, `err_flag` and `err_idx`.
- R10: While `inj_en` is high, every write into register `inj_idx` stores bit `inj_bit` as 1. With `inj_en` low, writes are stored unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rd_en | input | 1 | Pipeline uses the read port this cycle (low = idle) |
| rd_addr | input | 5 | Pipeline read index |
| rd_data | output | 32 | Pipeline read data (combinational) |
| wr_en | input | 1 | Pipeline uses the write port this cycle (low = idle) |
| wr_addr | input | 5 | Pipeline write index |
| wr_data | input | 32 | Pipeline write data |
| err_clr | input | 1 | Clears the sticky error flag |
| chk_valid | output | 1 | One-cycle pulse: a compare finished |
| chk_fail | output | 1 | The compare reported with `chk_valid` mismatched |
| chk_idx | output | 5 | Index of the register just compared |
| err_flag | output | 1 | Sticky defect flag |
| err_idx | output | 5 | Captured failing index |
| test_idx | output | 5 | Index currently under test |
| redir_on | output | 1 | Accesses to `test_idx` are redirected to the spare |
| inj_en | input | 1 | Stuck-at-one hook enable |
| inj_idx | input | 5 | Register affected by the hook |
| inj_bit | input | 5 | Bit forced to one by the hook |

## Verification
A stale or lost spare value shows at the ports as a corrupted architectural word. The bench sees it on the first pipeline read of that index once its restore is done, which is within a few cycles when the ports are idle. A phase register that advances while a port is busy, or that skips a phase, shifts the `chk_valid` cadence away from one pulse per four idle cycles, or produces a pulse under a held read. The bench sees this within one register's test. An LFSR or compare fault changes which injected-bit compares fail, so it shows at the first `chk_valid` of the affected register, which the bench predicts word by word.

// File: rtl/rft_pkg.sv
// Shared types for the online register file tester.
// Assumes nothing beyond IEEE 1800-2017 enum support.
package rft_pkg;

    // Test phase of the register currently under test; order is behaviour.
    typedef enum logic [1:0] {
        PH_COPY    = 2'd0,
        PH_WRITE   = 2'd1,
        PH_CHECK   = 2'd2,
        PH_RESTORE = 2'd3
    } rft_phase_e;

endpackage

// File: rtl/rft_lfsr.sv
// Fibonacci LFSR producing the test word.
// Shifts left; the new LSB is the XOR of the state bits selected by TAPS.
// Assumes SEED is nonzero. Steps only when step is high.
module rft_lfsr #(
    parameter int          W    = 32,
    parameter logic [W-1:0] TAPS = 32'h8020_0003,
    parameter logic [W-1:0] SEED = 32'h1D87_2B41
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         step,
    output logic [W-1:0] word
);

    logic fb;

    // Feedback bit from the tap mask.
    always_comb fb = ^(word & TAPS);

    // State register: reload the seed on reset, shift on step.
    always_ff @(posedge clk) begin
        if (!rst_n)    word <= SEED;
        else if (step) word <= {word[W-2:0], fb};
    end

endmodule

// File: rtl/rft_array.sv
// Register file storage with one read decoder and one write decoder.
// Reset clears all entries. A stuck-at-one hook ORs a single bit into
// every write aimed at the selected entry while inj_en is high.
module rft_array #(
    parameter int DATA_W = 32,
    parameter int REGS   = 32,
    parameter int IDX_W  = $clog2(REGS),
    parameter int BIT_W  = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  raddr,
    output logic [DATA_W-1:0] rdata,
    input  logic              we,
    input  logic [IDX_W-1:0]  waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              inj_en,
    input  logic [IDX_W-1:0]  inj_idx,
    input  logic [BIT_W-1:0]  inj_bit
);

    logic [DATA_W-1:0] rows [REGS];
    logic [DATA_W-1:0] stuck_mask;

    // Single-bit mask used by the fault hook.
    always_comb stuck_mask = DATA_W'(1) << inj_bit;

    // Read decoder: select one row by the read index.
    always_comb rdata = rows[raddr];

    for (genvar i = 0; i < REGS; i++) begin : g_row
        logic [DATA_W-1:0] q;
        logic              hit;

        // Write decoder output for this row.
        always_comb hit = we && (waddr == IDX_W'(i));

        // Row storage, with the optional stuck bit applied on write.
        always_ff @(posedge clk) begin
            if (!rst_n)   q <= '0;
            else if (hit) q <= (inj_en && inj_idx == IDX_W'(i)) ? (wdata | stuck_mask) : wdata;
        end

        assign rows[i] = q;
    end

endmodule

// File: rtl/rft_seq.sv
// Four-phase test sequencer: copy, write, check, restore.
// Each phase waits for the port it needs to be idle. Holds the spare
// register and the redirect flag, and reports compare results and errors.
// Assumes the pipeline write port is idle in any cycle where restore fires.
module rft_seq
    import rft_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int REGS   = 32,
    parameter int IDX_W  = $clog2(REGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_busy,
    input  logic              wr_busy,
    input  logic              pw_hit,
    input  logic [DATA_W-1:0] pw_data,
    input  logic [DATA_W-1:0] arr_rdata,
    input  logic [DATA_W-1:0] test_word,
    input  logic              err_clr,
    output logic              t_we,
    output logic [DATA_W-1:0] t_wdata,
    output logic [IDX_W-1:0]  idx,
    output logic              redir,
    output logic [DATA_W-1:0] spare,
    output logic              lfsr_step,
    output logic              chk_valid,
    output logic              chk_fail,
    output logic [IDX_W-1:0]  chk_idx,
    output logic              err_flag,
    output logic [IDX_W-1:0]  err_idx
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(REGS - 1);

    rft_phase_e ph;
    logic copy_go, write_go, check_go, rest_go, mismatch;

    // Phase enables gated by the idle port each phase needs.
    always_comb begin
        copy_go  = (ph == PH_COPY)    && !rd_busy;
        write_go = (ph == PH_WRITE)   && !wr_busy;
        check_go = (ph == PH_CHECK)   && !rd_busy;
        rest_go  = (ph == PH_RESTORE) && !wr_busy;
        mismatch = arr_rdata != test_word;
    end

    // Test write port: random word in the write phase, saved value on restore.
    always_comb begin
        t_we      = write_go || rest_go;
        t_wdata   = rest_go ? spare : test_word;
        lfsr_step = rest_go;
    end

    // Phase register: step to the next phase when its enable fires.
    always_ff @(posedge clk) begin
        if (!rst_n) ph <= PH_COPY;
        else if (copy_go)  ph <= PH_WRITE;
        else if (write_go) ph <= PH_CHECK;
        else if (check_go) ph <= PH_RESTORE;
        else if (rest_go)  ph <= PH_COPY;
    end

    // Index under test: advances after restore, wrapping past the last entry.
    always_ff @(posedge clk) begin
        if (!rst_n)       idx <= '0;
        else if (rest_go) idx <= (idx == LAST_IDX) ? '0 : idx + 1'b1;
    end

    // Redirect window: opens on copy, closes on restore.
    always_ff @(posedge clk) begin
        if (!rst_n)       redir <= 1'b0;
        else if (copy_go) redir <= 1'b1;
        else if (rest_go) redir <= 1'b0;
    end

    // Spare register: takes the copy, forwarding a same-cycle pipeline write.
    always_ff @(posedge clk) begin
        if (!rst_n)               spare <= '0;
        else if (copy_go)         spare <= pw_hit ? pw_data : arr_rdata;
        else if (redir && pw_hit) spare <= pw_data;
    end

    // Compare result: one-cycle pulse with its index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chk_valid <= 1'b0;
            chk_fail  <= 1'b0;
            chk_idx   <= '0;
        end else begin
            chk_valid <= check_go;
            chk_fail  <= check_go && mismatch;
            if (check_go) chk_idx <= idx;
        end
    end

    // Sticky error flag and captured index; a new failure beats a clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_flag <= 1'b0;
            err_idx  <= '0;
        end else if (check_go && mismatch) begin
            err_flag <= 1'b1;
            if (!err_flag || err_clr) err_idx <= idx;
        end else if (err_clr) begin
            err_flag <= 1'b0;
        end
    end

endmodule

// File: rtl/rf_online_tester.sv
// Top level: register file plus background tester.
// The pipeline owns both ports whenever rd_en / wr_en are high; the tester
// borrows a port only when it is idle. Accesses to the index under test are
// served by the spare register while the redirect window is open.
module rf_online_tester #(
    parameter int          DATA_W = 32,
    parameter int          REGS   = 32,
    parameter logic [31:0] SEED   = 32'h1D87_2B41,
    parameter logic [31:0] TAPS   = 32'h8020_0003
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      rd_en,
    input  logic [$clog2(REGS)-1:0]   rd_addr,
    output logic [DATA_W-1:0]         rd_data,
    input  logic                      wr_en,
    input  logic [$clog2(REGS)-1:0]   wr_addr,
    input  logic [DATA_W-1:0]         wr_data,
    input  logic                      err_clr,
    output logic                      chk_valid,
    output logic                      chk_fail,
    output logic [$clog2(REGS)-1:0]   chk_idx,
    output logic                      err_flag,
    output logic [$clog2(REGS)-1:0]   err_idx,
    output logic [$clog2(REGS)-1:0]   test_idx,
    output logic                      redir_on,
    input  logic                      inj_en,
    input  logic [$clog2(REGS)-1:0]   inj_idx,
    input  logic [$clog2(DATA_W)-1:0] inj_bit
);

    localparam int IDX_W = $clog2(REGS);
    localparam int BIT_W = $clog2(DATA_W);

    logic [IDX_W-1:0]  arr_raddr, arr_waddr;
    logic [DATA_W-1:0] arr_rdata, arr_wdata, t_wdata, spare, test_word;
    logic              arr_we, t_we, pw_hit, pw_to_arr, lfsr_step;

    // Port steering: pipeline first, tester on idle ports; redirected writes skip the array.
    always_comb begin
        pw_hit    = wr_en && (wr_addr == test_idx);
        pw_to_arr = wr_en && !(redir_on && pw_hit);
        arr_raddr = rd_en ? rd_addr : test_idx;
        arr_we    = pw_to_arr || t_we;
        arr_waddr = wr_en ? wr_addr : test_idx;
        arr_wdata = wr_en ? wr_data : t_wdata;
        rd_data   = (redir_on && rd_addr == test_idx) ? spare : arr_rdata;
    end

    rft_array #(.DATA_W(DATA_W), .REGS(REGS), .IDX_W(IDX_W), .BIT_W(BIT_W)) u_array (
        .clk(clk), .rst_n(rst_n),
        .raddr(arr_raddr), .rdata(arr_rdata),
        .we(arr_we), .waddr(arr_waddr), .wdata(arr_wdata),
        .inj_en(inj_en), .inj_idx(inj_idx), .inj_bit(inj_bit)
    );

    rft_lfsr #(.W(DATA_W), .TAPS(DATA_W'(TAPS)), .SEED(DATA_W'(SEED))) u_lfsr (
        .clk(clk), .rst_n(rst_n), .step(lfsr_step), .word(test_word)
    );

    rft_seq #(.DATA_W(DATA_W), .REGS(REGS), .IDX_W(IDX_W)) u_seq (
        .clk(clk), .rst_n(rst_n),
        .rd_busy(rd_en), .wr_busy(wr_en),
        .pw_hit(pw_hit), .pw_data(wr_data),
        .arr_rdata(arr_rdata), .test_word(test_word), .err_clr(err_clr),
        .t_we(t_we), .t_wdata(t_wdata), .idx(test_idx), .redir(redir_on),
        .spare(spare), .lfsr_step(lfsr_step),
        .chk_valid(chk_valid), .chk_fail(chk_fail), .chk_idx(chk_idx),
        .err_flag(err_flag), .err_idx(err_idx)
    );

endmodule

// File: rtl/rft_checker.sv
// Port-level protocol checks for rf_online_tester, attached by bind.
// Assumes a synchronous active-low reset on rst_n.
module rft_checker #(
    parameter int AW   = 5,
    parameter int REGS = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          rd_en,
    input logic          wr_en,
    input logic          err_clr,
    input logic          chk_valid,
    input logic          chk_fail,
    input logic          err_flag,
    input logic          redir_on,
    input logic [AW-1:0] test_idx
);

    localparam logic [AW-1:0] LAST = AW'(REGS - 1);

    a_r3_copy_needs_read_idle: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(redir_on) |-> !$past(rd_en));

    a_r3_restore_needs_write_idle: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(redir_on) |-> !$past(wr_en));

    a_r4_check_needs_read_idle: assert property (@(posedge clk) disable iff (!rst_n)
        chk_valid |-> !$past(rd_en));

    a_r7_check_inside_redirect: assert property (@(posedge clk) disable iff (!rst_n)
        chk_valid |-> redir_on);

    a_r5_index_steps_by_one: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(test_idx) |-> test_idx == (($past(test_idx) == LAST) ? '0 : $past(test_idx) + 1'b1));

    a_r5_index_moves_on_restore: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(test_idx) |-> $fell(redir_on));

    a_r6_fail_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_valid && chk_fail) |-> err_flag);

    a_r6_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (err_flag && !err_clr) |=> err_flag);

    a_r6_flag_rises_on_fail: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_flag) |-> (chk_valid && chk_fail));

endmodule

bind rf_online_tester rft_checker #(.AW(IDX_W), .REGS(REGS)) u_chk (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .wr_en(wr_en), .err_clr(err_clr),
    .chk_valid(chk_valid), .chk_fail(chk_fail), .err_flag(err_flag),
    .redir_on(redir_on), .test_idx(test_idx)
);

// File: tb/rf_online_tester_tb.sv
// Directed bench for rf_online_tester: one task per scenario.
module rf_online_tester_tb;

    localparam logic [31:0] SEED = 32'h1D87_2B41;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rd_en = 1'b0, wr_en = 1'b0, err_clr = 1'b0, inj_en = 1'b0;
    logic [4:0]  rd_addr = '0, wr_addr = '0, inj_idx = '0, inj_bit = '0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        chk_valid, chk_fail, err_flag, redir_on;
    logic [4:0]  chk_idx, err_idx, test_idx;

    int          checks = 0, failures = 0, cyc = 0, pulses = 0;
    logic        mon_on = 1'b0, fail_seen = 1'b0, prev_redir = 1'b0;
    logic [4:0]  m_idx = '0;
    logic [31:0] m_lfsr = SEED;
    logic [31:0] shadow [32];

    rf_online_tester u_dut (
        .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .err_clr(err_clr),
        .chk_valid(chk_valid), .chk_fail(chk_fail), .chk_idx(chk_idx),
        .err_flag(err_flag), .err_idx(err_idx), .test_idx(test_idx), .redir_on(redir_on),
        .inj_en(inj_en), .inj_idx(inj_idx), .inj_bit(inj_bit)
    );

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [31:0] lfsr_next(input logic [31:0] s);
        return {s[30:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
    endfunction

    task automatic check(input bit ok, input string what, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    task automatic report();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    // Result monitor: order, wrap and predicted compare outcome of every pulse.
    always @(negedge clk) begin
        if (mon_on && chk_valid) begin
            logic exp_fail;
            exp_fail = inj_en && (inj_idx == chk_idx) && !m_lfsr[inj_bit];
            check(chk_idx == m_idx, "R5 test order", 64'(chk_idx), 64'(m_idx));
            check(chk_fail == exp_fail, "R2 R6 compare outcome", 64'(chk_fail), 64'(exp_fail));
            if (exp_fail) fail_seen = 1'b1;
            pulses++;
            m_idx = m_idx + 1'b1;
            m_lfsr = lfsr_next(m_lfsr);
        end
    end

    task automatic idle(input int n);
        rd_en = 1'b0; wr_en = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    task automatic pwrite(input logic [4:0] a, input logic [31:0] d);
        rd_en = 1'b0; wr_en = 1'b1; wr_addr = a; wr_data = d;
        shadow[a] = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic pread_check(input logic [4:0] a, input logic [31:0] exp, input string what);
        wr_en = 1'b0; rd_en = 1'b1; rd_addr = a;
        #1;
        check(rd_data == exp, what, 64'(rd_data), 64'(exp));
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic wait_redir_edge(input bit rising);
        prev_redir = redir_on;
        forever begin
            @(negedge clk);
            if (rising && !prev_redir && redir_on) break;
            if (!rising && prev_redir && !redir_on) break;
            prev_redir = redir_on;
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0; rd_en = 1'b1; rd_addr = 5'd3;
        repeat (5) @(negedge clk);
        #1;
        check(rd_data == 32'h0, "R9 register cleared", 64'(rd_data), 64'h0);
        check({chk_valid, chk_fail, err_flag, redir_on} == 4'b0, "R9 flags cleared",
              64'({chk_valid, chk_fail, err_flag, redir_on}), 64'h0);
        check({test_idx, err_idx, chk_idx} == 15'h0, "R9 indices cleared",
              64'({test_idx, err_idx, chk_idx}), 64'h0);
        for (int i = 0; i < 32; i++) shadow[i] = '0;
        rd_en = 1'b0;
        @(negedge clk);
        rst_n = 1'b1; mon_on = 1'b1;
    endtask

    task automatic t_sweep();
        int first = 0, last = 0, bad = 0;
        rd_en = 1'b0; wr_en = 1'b0;
        for (int p = 0; p < 34; p++) begin
            do @(negedge clk); while (!chk_valid);
            if (p == 0) first = cyc;
            else if (cyc - last != 4) bad++;
            if (p == 32) check(cyc - first == 128, "R4 32 registers in 128 cycles", 64'(cyc - first), 64'd128);
            last = cyc;
        end
        check(bad == 0, "R4 one result per 4 idle cycles", 64'(bad), 64'd0);
    endtask

    task automatic t_preserve();
        for (int r = 0; r < 32; r++) pwrite(5'(r), 32'hC3A5_0000 ^ (32'h0101_0101 * 32'(r + 1)));
        idle(300);
        for (int r = 0; r < 32; r++) pread_check(5'(r), shadow[r], "R1 value preserved across tests");
    endtask

    task automatic t_stall();
        int p0;
        logic [4:0] i0;
        p0 = pulses; rd_en = 1'b1; rd_addr = 5'd0;
        repeat (40) @(negedge clk);
        check(pulses == p0, "R3 no compare while read port busy", 64'(pulses - p0), 64'd0);
        #1;
        check(rd_data == shadow[0], "R1 read during stall", 64'(rd_data), 64'(shadow[0]));
        rd_en = 1'b0; wr_en = 1'b1; wr_addr = 5'd5; wr_data = shadow[5];
        i0 = test_idx;
        repeat (40) @(negedge clk);
        check(test_idx == i0, "R3 no restore while write port busy", 64'(test_idx), 64'(i0));
        wr_en = 1'b0;
        idle(8);
    endtask

    task automatic t_redirect();
        logic [4:0] x;
        wait_redir_edge(1'b1);
        x = test_idx;
        for (int k = 0; k < 3; k++) begin
            wr_en = 1'b1; wr_addr = x; wr_data = 32'h5EED_0000 + 32'(k) + {27'h0, x};
            @(negedge clk);
        end
        shadow[x] = wr_data;
        check(redir_on && test_idx == x, "R3 write phase holds", 64'({redir_on, test_idx}), 64'({1'b1, x}));
        pread_check(x, shadow[x], "R7 read served by spare");
        idle(20);
        pread_check(x, shadow[x], "R7 redirected write restored");
    endtask

    task automatic t_copy_forward();
        logic [4:0] x;
        idle(1);
        wait_redir_edge(1'b0);
        x = test_idx;
        wr_en = 1'b1; wr_addr = x; wr_data = 32'hF00D_0000 | {27'h0, x};
        shadow[x] = wr_data;
        @(negedge clk);
        idle(20);
        pread_check(x, shadow[x], "R8 write during copy kept");
    endtask

    task automatic t_fault();
        logic [31:0] w;
        int steps;
        fail_seen = 1'b0;
        do @(negedge clk); while (test_idx != 5'd20);
        steps = (9 - int'(m_idx) + 32) % 32;
        w = m_lfsr;
        for (int s = 0; s < steps; s++) w = lfsr_next(w);
        inj_bit = 5'd0;
        for (int b = 31; b >= 0; b--) if (!w[b]) inj_bit = 5'(b);
        inj_idx = 5'd9; inj_en = 1'b1;
        idle(160);
        do @(negedge clk); while (test_idx != 5'd20);
        inj_en = 1'b0;
        check(fail_seen == 1'b1, "R10 stuck bit produced a mismatch", 64'(fail_seen), 64'd1);
        check(err_flag == 1'b1, "R6 error flag set", 64'(err_flag), 64'd1);
        check(err_idx == 5'd9, "R6 failing index captured", 64'(err_idx), 64'd9);
        idle(200);
        check(err_flag == 1'b1, "R6 flag sticky after clean passes", 64'(err_flag), 64'd1);
        err_clr = 1'b1;
        @(negedge clk);
        err_clr = 1'b0;
        check(err_flag == 1'b0, "R6 flag cleared", 64'(err_flag), 64'd0);
        idle(200);
        check(err_flag == 1'b0, "R10 no mismatch with hook off", 64'(err_flag), 64'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=running expected=done");
        report();
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_sweep();
        t_preserve();
        t_stall();
        t_redirect();
        t_copy_forward();
        t_fault();
        for (int r = 0; r < 32; r++)
            if (r != 9) pread_check(5'(r), shadow[r], "R1 final contents");
        report();
    end

endmodule